// File: doc/BRIEF.md
# Range-Matching Translation Cache with Recency Replacement

This block is a small, fully associative cache of address translations. Each slot holds three things: a virtual start page, a region size given as a power of two of at least 4 KiB, and a physical page start. A lookup presents a virtual address. One cycle later the block reports hit or miss. On a hit it also reports the matching physical page start and the translated address. The translated address is the page start with the low twelve bits of the virtual address placed beneath it.

A separate insert port loads a new translation. When a slot has never been filled, the insert uses the free slot with the lowest index. Once every slot is in use, the insert replaces the slot that was used least recently. Recency is kept as a rank per slot, where rank 0 is the most recent. A lookup can either promote the slot it hits or leave the order alone, as the caller chooses.

A miss only raises the miss flag. Fetching the translation is left to an outside handler, which then uses the insert port.

Top module: `xlat_cache`

## Requirements
- R1: A valid slot with start page S and size code L (region of 2^L bytes, L from 12 to the address width, start aligned to the region) matches address A exactly when S*4096 <= A < S*4096 + 2^L. An address equal to the region end, or one byte below the start, misses.
- R2: On a hit, rsp_page is the slot's physical page number followed by twelve zero bits. rsp_pa equals rsp_page with its low twelve bits replaced by bits 11:0 of the looked-up address.
- R3: A lookup accepted in cycle T gives rsp_valid=1 in cycle T+1, with exactly one of rsp_hit or rsp_miss set. On a miss, rsp_page and rsp_pa are zero. Without an accepted lookup, all three flags are 0.
- R4: While any slot is free, an insert fills the lowest-index free slot, and no existing translation is lost.
- R5: When all slots are valid, an insert overwrites the slot with the least recent rank. The translation that slot held then misses.
- R6: A newly inserted translation becomes the most recent entry.
- R7: A hit with lk_upd=1 moves the hit slot to the most recent position. A lookup with lk_upd=0, or a miss, leaves the recency order unchanged.
- R8: When more than one slot matches, the result comes from the matching slot that is most recent.
- R9: After reset every slot is free and zeroed, and every lookup misses.
- R10: When ins_valid and lk_valid are high in the same cycle, the insert is performed. The lookup is dropped: no response appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_upd | input | 1 | Promote the hit slot to most recent |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VA_W-12 | Start page of the new region |
| ins_lg | input | LG_W | Log2 of the region size in bytes |
| ins_ppn | input | PA_W-12 | Physical page number of the new region |
| rsp_valid | output | 1 | Response present (one cycle after lookup) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed |
| rsp_page | output | PA_W | Physical page start of the hit |
| rsp_pa | output | PA_W | Translated physical address |

## Verification
The assertions check the following on every cycle:
- The ranks always form a permutation.
- A touched slot always lands at rank 0.
- The order stays fixed through a lookup that does not update it.
- An insert grows the count of valid slots while free slots remain.
- An insert suppresses the next response.
- Hit and miss are exclusive.
- The low bits of rsp_pa carry through from the looked-up address.

The bench scenarios are needed for the behaviours that depend on history:
- which translation is evicted after a given sequence of promotions and non-promoting lookups;
- which of two overlapping regions wins;
- the exact upper and lower edges of a large region.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
   // bytes per page = 2**PG_SHIFT
   localparam int unsigned PG_SHIFT = 12;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/xlat_cache_store.sv
module xlat_cache_store
   import xlat_cache_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 8,
   parameter int unsigned VPN_W     = 20,
   parameter int unsigned PPN_W     = 20,
   parameter int unsigned LG_W      = 6,
   localparam int unsigned IW       = idx_width(N_ENTRIES)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [IW-1:0]                   wr_idx,
   input  logic [VPN_W-1:0]                wr_vpn,
   input  logic [LG_W-1:0]                 wr_lg,
   input  logic [PPN_W-1:0]                wr_ppn,
   input  logic [VPN_W-1:0]                q_vpn,
   output logic [N_ENTRIES-1:0]            valid_o,
   output logic [N_ENTRIES-1:0]            hit_vec,
   output logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_o
);
   logic [N_ENTRIES-1:0]            val_q;
   logic [N_ENTRIES-1:0][VPN_W-1:0] vpn_q;
   logic [N_ENTRIES-1:0][LG_W-1:0]  lg_q;
   logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q <= '0;
         vpn_q <= '0;
         lg_q  <= '0;
         ppn_q <= '0;
      end else if (wr_en) begin
         val_q[wr_idx] <= 1'b1;
         vpn_q[wr_idx] <= wr_vpn;
         lg_q[wr_idx]  <= wr_lg;
         ppn_q[wr_idx] <= wr_ppn;
      end
   end

   genvar g, k;
   generate
      for (g = 0; g < N_ENTRIES; g++) begin : g_slot
         logic [VPN_W-1:0] keep;
         // page bit k takes part in the compare only above the region size
         for (k = 0; k < VPN_W; k++) begin : g_bit
            localparam int unsigned KV = k + PG_SHIFT;
            assign keep[k] = (lg_q[g] <= LG_W'(KV));
         end
         assign hit_vec[g] = val_q[g] && (((q_vpn ^ vpn_q[g]) & keep) == '0);
      end
   endgenerate

   assign valid_o = val_q;
   assign ppn_o   = ppn_q;
endmodule

// File: rtl/xlat_cache_age.sv
module xlat_cache_age
   import xlat_cache_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 8,
   localparam int unsigned IW       = idx_width(N_ENTRIES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         touch_en,
   input  logic [IW-1:0]                touch_idx,
   input  logic [N_ENTRIES-1:0]         cand_vec,
   output logic [IW-1:0]                best_idx,
   output logic [IW-1:0]                lru_idx,
   output logic [N_ENTRIES-1:0][IW-1:0] rank_o
);
   logic [N_ENTRIES-1:0][IW-1:0] rank_q;
   logic [IW-1:0]                old_rank;
   logic [IW-1:0]                best_rank;
   logic                         found;

   assign old_rank = rank_q[touch_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_ENTRIES; i++) rank_q[i] <= IW'(i);
      end else if (touch_en) begin
         for (int i = 0; i < N_ENTRIES; i++) begin
            if (touch_idx == IW'(i))
               rank_q[i] <= '0;
            else if (rank_q[i] < old_rank)
               rank_q[i] <= rank_q[i] + 1'b1;
         end
      end
   end

   // youngest candidate wins
   always_comb begin
      best_idx  = '0;
      best_rank = '1;
      found     = 1'b0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (cand_vec[i] && (!found || rank_q[i] < best_rank)) begin
            found     = 1'b1;
            best_rank = rank_q[i];
            best_idx  = IW'(i);
         end
      end
   end

   always_comb begin
      lru_idx = '0;
      for (int i = 0; i < N_ENTRIES; i++)
         if (rank_q[i] == IW'(N_ENTRIES - 1)) lru_idx = IW'(i);
   end

   assign rank_o = rank_q;

   logic [N_ENTRIES-1:0] occ;
   always_comb begin
      occ = '0;
      for (int i = 0; i < N_ENTRIES; i++) occ[rank_q[i]] = 1'b1;
   end

   // R5
   rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ == {N_ENTRIES{1'b1}});

   // R6
   mru_on_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> rank_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_cache_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 8,
   parameter int unsigned VA_W      = 32,
   parameter int unsigned PA_W      = 32,
   parameter int unsigned LG_W      = $clog2(VA_W + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lk_valid,
   input  logic [VA_W-1:0]          lk_va,
   input  logic                     lk_upd,
   input  logic                     ins_valid,
   input  logic [VA_W-PG_SHIFT-1:0] ins_vpn,
   input  logic [LG_W-1:0]          ins_lg,
   input  logic [PA_W-PG_SHIFT-1:0] ins_ppn,
   output logic                     rsp_valid,
   output logic                     rsp_hit,
   output logic                     rsp_miss,
   output logic [PA_W-1:0]          rsp_page,
   output logic [PA_W-1:0]          rsp_pa
);
   localparam int unsigned VPN_W = VA_W - PG_SHIFT;
   localparam int unsigned PPN_W = PA_W - PG_SHIFT;
   localparam int unsigned IW    = idx_width(N_ENTRIES);

   generate
      if (N_ENTRIES < 2) begin : g_bad_depth
         $error("xlat_cache: N_ENTRIES must be at least 2");
      end
      if (VA_W <= PG_SHIFT || PA_W <= PG_SHIFT) begin : g_bad_width
         $error("xlat_cache: address widths must exceed the page offset");
      end
      if ((2 ** LG_W) <= VA_W) begin : g_bad_lg
         $error("xlat_cache: LG_W too narrow for VA_W");
      end
   endgenerate

   logic [N_ENTRIES-1:0]            valid_v, hit_vec;
   logic [N_ENTRIES-1:0][PPN_W-1:0] ppn_v;
   logic [N_ENTRIES-1:0][IW-1:0]    ranks;
   logic [IW-1:0]                   best_idx, lru_idx, free_idx, ins_idx, touch_idx;
   logic                            any_free, lk_go, hit_any, touch_en;

   always_comb begin
      free_idx = '0;
      any_free = 1'b0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (!valid_v[i]) begin
            free_idx = IW'(i);
            any_free = 1'b1;
         end
      end
   end

   assign ins_idx   = any_free ? free_idx : lru_idx;
   assign lk_go     = lk_valid && !ins_valid;
   assign hit_any   = |hit_vec;
   assign touch_en  = ins_valid || (lk_go && hit_any && lk_upd);
   assign touch_idx = ins_valid ? ins_idx : best_idx;

   xlat_cache_store #(
      .N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .LG_W(LG_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ins_valid),
      .wr_idx  (ins_idx),
      .wr_vpn  (ins_vpn),
      .wr_lg   (ins_lg),
      .wr_ppn  (ins_ppn),
      .q_vpn   (lk_va[VA_W-1:PG_SHIFT]),
      .valid_o (valid_v),
      .hit_vec (hit_vec),
      .ppn_o   (ppn_v)
   );

   xlat_cache_age #(.N_ENTRIES(N_ENTRIES)) u_age (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (touch_en),
      .touch_idx (touch_idx),
      .cand_vec  (hit_vec),
      .best_idx  (best_idx),
      .lru_idx   (lru_idx),
      .rank_o    (ranks)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_page  <= '0;
         rsp_pa    <= '0;
      end else begin
         rsp_valid <= lk_go;
         rsp_hit   <= lk_go && hit_any;
         rsp_miss  <= lk_go && !hit_any;
         if (lk_go && hit_any) begin
            rsp_page <= {ppn_v[best_idx], {PG_SHIFT{1'b0}}};
            rsp_pa   <= {ppn_v[best_idx], lk_va[PG_SHIFT-1:0]};
         end else begin
            rsp_page <= '0;
            rsp_pa   <= '0;
         end
      end
   end

   // R10
   ins_over_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid |=> !rsp_valid);

   // R4
   fill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !(&valid_v)) |=> $countones(valid_v) == $past($countones(valid_v)) + 1);

   // R7
   order_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && !lk_upd && !ins_valid) |=> $stable(ranks));

   // R3
   hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == (rsp_hit || rsp_miss) && !(rsp_hit && rsp_miss));

   // R2
   pa_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_pa[PG_SHIFT-1:0] == $past(lk_va[PG_SHIFT-1:0]) &&
                   rsp_pa[PA_W-1:PG_SHIFT] == rsp_page[PA_W-1:PG_SHIFT]));
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_va = '0;
   logic        lk_upd = 1'b0;
   logic        ins_valid = 1'b0;
   logic [19:0] ins_vpn = '0;
   logic [5:0]  ins_lg = '0;
   logic [19:0] ins_ppn = '0;
   logic        rsp_valid, rsp_hit, rsp_miss;
   logic [31:0] rsp_page, rsp_pa;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   xlat_cache u_xlat_cache (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_va(lk_va), .lk_upd(lk_upd),
      .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_lg(ins_lg), .ins_ppn(ins_ppn),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_page(rsp_page), .rsp_pa(rsp_pa)
   );

   typedef struct packed {
      logic        is_lk;
      logic [31:0] addr;
      logic [5:0]  lg;
      logic [19:0] ppn;
      logic        upd;
      logic        hit;
      logic [31:0] pa;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h0000_1000, 6'd12, 20'hAAAAA, 1'b0, 1'b0, 32'h0},          // insert 4K
      '{1'b1, 32'h0000_1234, 6'd0,  20'h0,     1'b1, 1'b1, 32'hAAAAA234},   // R1 R2 inside
      '{1'b1, 32'h0000_2000, 6'd0,  20'h0,     1'b0, 1'b0, 32'h0},          // R1 end excluded
      '{1'b1, 32'h0000_0FFF, 6'd0,  20'h0,     1'b0, 1'b0, 32'h0},          // R1 below start
      '{1'b0, 32'h0040_0000, 6'd22, 20'h12345, 1'b0, 1'b0, 32'h0},          // insert 4M
      '{1'b1, 32'h007F_FABC, 6'd0,  20'h0,     1'b1, 1'b1, 32'h12345ABC},   // R1 top byte page
      '{1'b1, 32'h0080_0000, 6'd0,  20'h0,     1'b0, 1'b0, 32'h0},          // R1 past end
      '{1'b0, 32'h0040_0000, 6'd12, 20'h55555, 1'b0, 1'b0, 32'h0},          // overlap, newest
      '{1'b1, 32'h0040_0010, 6'd0,  20'h0,     1'b0, 1'b1, 32'h55555010},   // R8 newest wins
      '{1'b1, 32'h0040_1010, 6'd0,  20'h0,     1'b1, 1'b1, 32'h12345010},   // promote big one
      '{1'b1, 32'h0040_0010, 6'd0,  20'h0,     1'b0, 1'b1, 32'h12345010}    // R8 R7 promoted wins
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_insert(input logic [31:0] start, input logic [5:0] lg, input logic [19:0] ppn);
      @(negedge clk);
      ins_valid = 1'b1;
      ins_vpn   = start[31:12];
      ins_lg    = lg;
      ins_ppn   = ppn;
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   task automatic do_lookup(input logic [31:0] va, input logic upd, input logic exp_hit,
                            input logic [31:0] exp_pa, input string req);
      @(negedge clk);
      lk_valid = 1'b1;
      lk_va    = va;
      lk_upd   = upd;
      @(negedge clk);
      lk_valid = 1'b0;
      lk_upd   = 1'b0;
      check(rsp_valid === 1'b1, {req, " R3 valid"}, 32'(rsp_valid), 32'd1);
      check(rsp_hit === exp_hit && rsp_miss === !exp_hit, {req, " hit"}, 32'(rsp_hit), 32'(exp_hit));
      check(rsp_pa === exp_pa, {req, " pa"}, rsp_pa, exp_pa);
      check(rsp_page === (exp_pa & 32'hFFFF_F000), {req, " R2 page"}, rsp_page, exp_pa & 32'hFFFF_F000);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R9 reset state
      repeat (3) @(negedge clk);
      check(rsp_valid === 1'b0 && rsp_hit === 1'b0 && rsp_miss === 1'b0, "R9 flags", 32'(rsp_valid), 32'd0);
      check(rsp_pa === 32'h0, "R9 pa", rsp_pa, 32'h0);
      rst_n = 1'b1;
      do_lookup(32'h0000_0000, 1'b1, 1'b0, 32'h0, "R9 zero addr");
      do_lookup(32'h0000_0ABC, 1'b0, 1'b0, 32'h0, "R9 low page");

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].is_lk)
            do_lookup(VECS[i].addr, VECS[i].upd, VECS[i].hit, VECS[i].pa, $sformatf("R1/vec%0d", i));
         else
            do_insert(VECS[i].addr, VECS[i].lg, VECS[i].ppn);
      end

      // R10 insert and lookup in the same cycle
      @(negedge clk);
      ins_valid = 1'b1; ins_vpn = 20'h00300; ins_lg = 6'd12; ins_ppn = 20'h77777;
      lk_valid  = 1'b1; lk_va = 32'h0000_1234; lk_upd = 1'b1;
      @(negedge clk);
      ins_valid = 1'b0; lk_valid = 1'b0; lk_upd = 1'b0;
      check(rsp_valid === 1'b0, "R10 dropped", 32'(rsp_valid), 32'd0);
      do_lookup(32'h0030_0444, 1'b0, 1'b1, 32'h77777444, "R10 insert done");

      // replacement order
      do_reset();
      for (int i = 0; i < 8; i++)
         do_insert(32'((32'h10 + i) << 12), 6'd12, 20'(32'h100 + i));
      for (int i = 0; i < 8; i++)
         do_lookup(32'((32'h10 + i) << 12) | 32'h0AB, 1'b0, 1'b1,
                   32'((32'h100 + i) << 12) | 32'h0AB, "R4 all kept");
      do_lookup(32'h0001_0000, 1'b0, 1'b1, 32'h0010_0000, "R7 no-update hit");
      do_insert(32'h0020_0000, 6'd12, 20'h00999);
      do_lookup(32'h0001_0000, 1'b0, 1'b0, 32'h0, "R5 lru evicted");
      do_lookup(32'h0001_1004, 1'b1, 1'b1, 32'h0010_1004, "R7 promote");
      do_insert(32'h0020_1000, 6'd12, 20'h00998);
      do_lookup(32'h0001_2000, 1'b0, 1'b0, 32'h0, "R7 promoted spared");
      do_lookup(32'h0001_1008, 1'b0, 1'b1, 32'h0010_1008, "R7 survivor");
      do_lookup(32'h0020_0010, 1'b0, 1'b1, 32'h0099_9010, "R5 new entry");
      do_lookup(32'h0020_1020, 1'b0, 1'b1, 32'h0099_8020, "R6 new entry");
      do_lookup(32'h0001_3000, 1'b0, 1'b1, 32'h0010_3000, "R5 next lru present");
      do_insert(32'h0020_2000, 6'd12, 20'h00997);
      do_lookup(32'h0001_3000, 1'b0, 1'b0, 32'h0, "R6 oldest evicted");
      do_lookup(32'h0020_1FFF, 1'b0, 1'b1, 32'h0099_8FFF, "R6 newest kept");
      do_lookup(32'h0020_2001, 1'b0, 1'b1, 32'h0099_7001, "R6 insert hit");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule